// File: doc/BRIEF.md
# Timed Pattern Ring Player

The block replays a stream of precomputed output events on a twelve-bit pin port, each at an exact clock cycle. Every event is one ring entry. The entry holds the pin word to apply and the number of 20-cycle slots to wait before the next entry is applied. A slower producer fills the ring through a valid/ready write port. The block picks the write location itself and shows it on `wr_slot`. The player drains the ring in order after a start pulse. All timing comes from a single down-counter, so the spacing between pin updates is fixed and does not vary by even one cycle.

The write port follows valid/ready rules. A word is taken on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the ring is full. While it is low, the producer must hold its word. A word offered while the ring is full is not stored and does not change the ring. The ring holds 64 entries. Its pointers wrap by overflowing naturally, with no compare against the end of the table. `fill` tells the producer how far it is ahead of the player.

If the next event falls due while the ring is empty, the pins keep their last value. The sticky `underrun` flag then rises and the player stops. Only a new start pulse clears the flag and resumes playback.

Top module: `pattern_ring_player`

## Requirements
- R1: After reset, `pins` is 0, `underrun` is 0, `fill` is 0, `wr_ready` is 1 and `wr_slot` is 0.
- R2: An accepted write (`wr_valid` and `wr_ready` high at a rising edge) stores {`wr_pins`, `wr_delay`} at index `wr_slot`. Without a concurrent read, `fill` rises by one and `wr_slot` advances by one modulo 64, both visible after that edge.
- R3: When `fill` is 64, `wr_ready` is 0. A word offered then is dropped: `fill` and `wr_slot` stay the same, and the stored entries play back unchanged.
- R4: If `start` is sampled high while the player is idle, the pin word of the oldest ring entry appears on `pins` after the next rising edge, and not before.
- R5: After an entry with delay field D ≥ 1 is applied, the next entry is applied exactly 20·D cycles later. `pins` does not change at any other edge.
- R6: A delay field of 0 is treated as 1, giving a spacing of exactly 20 cycles.
- R7: Each applied entry lowers `fill` by one, visible after the edge that applies it.
- R8: Playback goes from index 63 to index 0 and keeps the write order across the wrap.
- R9: If an event falls due while the ring is empty, `pins` holds its value and `underrun` becomes 1 at that edge. It stays 1, and the pins stay unchanged, even if new writes arrive, until the next `start`.
- R10: A `start` pulse while playing has no effect on timing or pin values. A `start` pulse while idle clears `underrun` after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Producer offers an entry |
| wr_ready | output | 1 | Ring can accept an entry (not full) |
| wr_pins | input | 12 | Pin word of the offered entry |
| wr_delay | input | 8 | Slots of 20 cycles until the following entry (0 means 1) |
| wr_slot | output | 6 | Ring index the next accepted entry will occupy |
| fill | output | 7 | Entries written but not yet applied (0 to 64) |
| start | input | 1 | Begin playback when idle; clears underrun |
| underrun | output | 1 | Sticky: an event fell due with the ring empty |
| pins | output | 12 | Output pin word |

## Verification
`fill` and `wr_slot` change one edge after an accepted write. The first pin word appears one edge after the edge that samples `start`. Each following word appears 20·max(D,1) edges after the previous one. `underrun` rises on the edge where the next word would have been due. All inputs are driven on falling edges and all outputs are sampled on falling edges. Every pin change is checked twice: at the falling edge just before its due rising edge, where the old value must still be present, and at the falling edge just after it, where the new value must be present. A change that comes one cycle early or one cycle late therefore fails a check.

// File: rtl/ring_player_pkg.sv
package ring_player_pkg;

  typedef enum logic {
    PL_IDLE = 1'b0,
    PL_RUN  = 1'b1
  } play_state_e;

endpackage

// File: rtl/ring_store.sv
module ring_store #(
  parameter int PIN_W = 12,
  parameter int DLY_W = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [PIN_W-1:0] wr_pins,
  input  logic [DLY_W-1:0] wr_dly,
  output logic [IDX_W-1:0] wr_slot,
  output logic [IDX_W:0]   fill,
  input  logic             rd_en,
  output logic             empty,
  output logic [PIN_W-1:0] rd_pins,
  output logic [DLY_W-1:0] rd_dly
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0] FULL_LVL = (IDX_W+1)'(DEPTH);

  logic [PIN_W-1:0] pin_mem [DEPTH];
  logic [DLY_W-1:0] dly_mem [DEPTH];
  logic [IDX_W:0]   wptr, rptr;
  logic             wr_fire;

  assign fill     = wptr - rptr;
  assign wr_ready = (fill != FULL_LVL);
  assign empty    = (fill == '0);
  assign wr_fire  = wr_valid && wr_ready;
  assign wr_slot  = wptr[IDX_W-1:0];
  assign rd_pins  = pin_mem[rptr[IDX_W-1:0]];
  assign rd_dly   = dly_mem[rptr[IDX_W-1:0]];

  // pointer lower bits index the ring; the extra bit tells full from empty
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_fire) wptr <= wptr + 1'b1;
      if (rd_en)   rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      pin_mem[wptr[IDX_W-1:0]] <= wr_pins;
      dly_mem[wptr[IDX_W-1:0]] <= wr_dly;
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL)
    else $error("fill beyond ring depth");

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FULL_LVL && !rd_en) |=> (fill == FULL_LVL && $stable(wr_slot)))
    else $error("full ring changed without a read");

  assert_write_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !rd_en) |=> (fill == $past(fill) + 1'b1))
    else $error("accepted write did not raise fill");

  assert_read_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr_valid && wr_ready)) |=> (fill == $past(fill) - 1'b1))
    else $error("applied entry did not lower fill");

  assert_no_read_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_en)
    else $error("read from empty ring");

endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int DLY_W    = 8,
  parameter int SLOT_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] dly,
  output logic             expired
);

  localparam int MAX_CYC = SLOT_CYC * ((1 << DLY_W) - 1);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] slots;
  logic [CNT_W-1:0] load_val;

  // a zero delay field still spends one full slot
  always_comb begin
    slots    = (dly == '0) ? CNT_W'(1) : CNT_W'(dly);
    load_val = slots * CNT_W'(SLOT_CYC) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1))
    else $error("timer skipped a cycle");

endmodule

// File: rtl/player_seq.sv
module player_seq
  import ring_player_pkg::*;
#(
  parameter int PIN_W    = 12,
  parameter int SLOT_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             expired,
  input  logic             empty,
  input  logic [PIN_W-1:0] rd_pins,
  output logic             rd_en,
  output logic [PIN_W-1:0] pins,
  output logic             underrun
);

  localparam int GAP_W = $clog2(SLOT_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(SLOT_CYC);

  play_state_e st;
  logic        due;

  assign due   = (st == PL_RUN) && expired;
  assign rd_en = due && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PL_IDLE;
      pins     <= '0;
      underrun <= 1'b0;
    end else begin
      case (st)
        PL_IDLE: if (start) begin
          st       <= PL_RUN;
          underrun <= 1'b0;
        end
        default: if (due) begin
          if (!empty) begin
            pins <= rd_pins;
          end else begin
            underrun <= 1'b1;
            st       <= PL_IDLE;
          end
        end
      endcase
    end
  end

  // spacing checker: cycles since the previous applied entry
  logic [GAP_W-1:0] gap;
  logic             have_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= '0;
      have_prev <= 1'b0;
    end else if (rd_en) begin
      gap       <= '0;
      have_prev <= 1'b1;
    end else begin
      if (st == PL_IDLE) have_prev <= 1'b0;
      if (gap != GAP_MAX) gap <= gap + 1'b1;
    end
  end

  assert_min_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && have_prev) |-> (gap >= GAP_MAX - 1'b1))
    else $error("pin updates closer than one slot");

  assert_pins_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(pins))
    else $error("pins changed outside an event");

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !start) |=> underrun)
    else $error("underrun cleared without start");

  assert_stop_on_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (st == PL_IDLE))
    else $error("player kept running after underrun");

endmodule

// File: rtl/pattern_ring_player.sv
module pattern_ring_player #(
  parameter int PIN_W    = 12,
  parameter int DLY_W    = 8,
  parameter int IDX_W    = 6,
  parameter int SLOT_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [PIN_W-1:0] wr_pins,
  input  logic [DLY_W-1:0] wr_delay,
  output logic [IDX_W-1:0] wr_slot,
  output logic [IDX_W:0]   fill,
  input  logic             start,
  output logic             underrun,
  output logic [PIN_W-1:0] pins
);

  logic             rd_en;
  logic             empty;
  logic             expired;
  logic [PIN_W-1:0] rd_pins;
  logic [DLY_W-1:0] rd_dly;

  ring_store #(
    .PIN_W(PIN_W),
    .DLY_W(DLY_W),
    .IDX_W(IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_pins (wr_pins),
    .wr_dly  (wr_delay),
    .wr_slot (wr_slot),
    .fill    (fill),
    .rd_en   (rd_en),
    .empty   (empty),
    .rd_pins (rd_pins),
    .rd_dly  (rd_dly)
  );

  slot_timer #(
    .DLY_W   (DLY_W),
    .SLOT_CYC(SLOT_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (rd_en),
    .dly    (rd_dly),
    .expired(expired)
  );

  player_seq #(
    .PIN_W   (PIN_W),
    .SLOT_CYC(SLOT_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .expired (expired),
    .empty   (empty),
    .rd_pins (rd_pins),
    .rd_en   (rd_en),
    .pins    (pins),
    .underrun(underrun)
  );

endmodule

// File: tb/tb_pattern_ring_player.sv
`timescale 1ns/1ps
module tb_pattern_ring_player;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [11:0] wr_pins = '0;
  logic [7:0]  wr_delay = '0;
  logic [5:0]  wr_slot;
  logic [6:0]  fill;
  logic        start = 1'b0;
  logic        underrun;
  logic [11:0] pins;

  always #5 clk = ~clk;

  pattern_ring_player dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_pins(wr_pins), .wr_delay(wr_delay), .wr_slot(wr_slot), .fill(fill),
    .start(start), .underrun(underrun), .pins(pins)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model of the ring
  int m_pins [64];
  int m_dly  [64];
  int head = 0;
  int tail = 0;
  int last_pins = 0;
  int last_dly = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int p, input int d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_pins  = 12'(p);
    wr_delay = 8'(d);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    m_pins[tail % 64] = p;
    m_dly[tail % 64]  = d;
    tail++;
  endtask

  function automatic int gap_of(input int d);
    return 20 * ((d == 0) ? 1 : d);
  endfunction

  task automatic start_play(input string req);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(pins == 12'(last_pins), {req, " no early update"}, pins, last_pins);
    chk(underrun == 1'b0, "R10 start clears underrun", underrun, 0);
    @(posedge clk);
    @(negedge clk);
    chk(pins == 12'(m_pins[head % 64]), {req, " first entry"}, pins, m_pins[head % 64]);
    last_pins = m_pins[head % 64];
    last_dly  = m_dly[head % 64];
    head++;
  endtask

  task automatic follow(input string req, input bit poke);
    int n = gap_of(last_dly);
    if (poke) begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (n - 7) @(posedge clk);
    end else begin
      repeat (n - 1) @(posedge clk);
    end
    @(negedge clk);
    chk(pins == 12'(last_pins), {req, " not early"}, pins, last_pins);
    @(posedge clk);
    @(negedge clk);
    chk(pins == 12'(m_pins[head % 64]), {req, " on time"}, pins, m_pins[head % 64]);
    last_pins = m_pins[head % 64];
    last_dly  = m_dly[head % 64];
    head++;
  endtask

  task automatic expect_underrun(input string req);
    int n = gap_of(last_dly);
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk(underrun == 1'b0, {req, " underrun not early"}, underrun, 0);
    @(posedge clk);
    @(negedge clk);
    chk(underrun == 1'b1, "R9 underrun raised when due", underrun, 1);
    chk(pins == 12'(last_pins), "R9 pins held at underrun", pins, last_pins);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pins == 12'd0, "R1 pins", pins, 0);
    chk(underrun == 1'b0, "R1 underrun", underrun, 0);
    chk(fill == 7'd0, "R1 fill", fill, 0);
    chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    chk(wr_slot == 6'd0, "R1 wr_slot", wr_slot, 0);
  endtask

  task automatic t_basic();
    push(12'h0A5, 1);
    push(12'h35C, 3);
    push(12'hF0F, 0);
    chk(fill == 7'd3, "R2 fill after writes", fill, 3);
    chk(wr_slot == 6'd3, "R2 wr_slot after writes", wr_slot, 3);
    start_play("R4");
    chk(fill == 7'd2, "R7 fill after first entry", fill, 2);
    follow("R5 one slot", 1'b0);
    follow("R5 three slots", 1'b0);
    expect_underrun("R6 zero delay");
  endtask

  task automatic t_restart();
    push(12'h111, 2);
    push(12'h222, 1);
    push(12'h333, 1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(pins == 12'(last_pins), "R9 writes do not move pins", pins, last_pins);
    chk(underrun == 1'b1, "R9 underrun sticky", underrun, 1);
    start_play("R10 restart");
    follow("R10 start while playing", 1'b1);
    follow("R5 after poke", 1'b0);
    expect_underrun("R5 last gap");
  endtask

  task automatic t_full_wrap();
    for (int i = 0; i < 64; i++) push((i * 37 + 5) & 12'hFFF, (i % 3 == 0) ? 2 : 1);
    chk(fill == 7'd64, "R3 fill at full", fill, 64);
    chk(wr_ready == 1'b0, "R3 wr_ready low when full", wr_ready, 0);
    // offer a word to the full ring; the model is not updated
    @(negedge clk);
    wr_valid = 1'b1;
    wr_pins  = 12'hFFF;
    wr_delay = 8'd1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(fill == 7'd64, "R3 fill unchanged by dropped word", fill, 64);
    chk(wr_slot == 6'd6, "R3 wr_slot unchanged by dropped word", wr_slot, 6);
    start_play("R8");
    chk(fill == 7'd63, "R7 fill after first entry", fill, 63);
    for (int i = 0; i < 63; i++) follow("R8 wrap order", 1'b0);
    expect_underrun("R3 R8 end of ring");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_restart();
    t_full_wrap();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule